// File: doc/BRIEF.md
# Interruptible Word Block-Move Engine

This block copies a run of 16-bit words from one place to another inside a small register memory, through a single memory port. A start request gives two byte addresses: where a pointer pair lives, and where a word count lives. The source pointer is stored at the pointer location. The destination pointer is stored at that location plus 2. The engine fetches both pointers and the count. It then repeats one transfer per word: it reads the word at the source and writes it at the destination. It adds 2 to both pointers and writes both of them back to the pointer pair.

An interrupt request can stop the move. It is only acted on at a transfer boundary, so that no word is left half-copied. When it stops the move, the engine stores the remaining count at the count location and flags the stop. Software restarts the move with a new start at the same two locations, which by then hold the advanced pointers and the remaining count. When the move finishes normally, the count location is never written.

Top module: `wbm_engine`

## Requirements
- R1: On start, the engine reads the source pointer from `ptr_loc_i`, the destination pointer from `ptr_loc_i+2` and the count from `cnt_loc_i`. `busy_o` is high from the cycle after start until the move ends.
- R2: Each transfer copies the word at the source address to the destination address, in ascending order. No word beyond the count is touched.
- R3: After every transfer, both pointers are advanced by 2 and written back, the source to `ptr_loc_i` and the destination to `ptr_loc_i+2`. The increment wraps from FFFEh to 0000h within 16 bits.
- R4: After the counted number of transfers, `done_o` pulses high for exactly one cycle and `busy_o` falls in the same cycle. The count location keeps its value.
- R5: A count of zero ends with a `done_o` pulse, with no memory write and the pointers unchanged.
- R6: `irq_i` is sampled only at the end of a transfer, after both pointer writes. If words remain, the engine writes the remaining count to `cnt_loc_i`, pulses `intr_o` for one cycle instead of `done_o`, and performs no further transfer.
- R7: An interrupt request present at the end of the final transfer is ignored. The move ends with `done_o` and the count location is unchanged.
- R8: A new start at the same locations after an interrupt finishes the move. The final memory then matches an uninterrupted move, and the count location holds the count stored at the interrupt.
- R9: Out of reset all outputs are low. The engine issues no memory write while idle, and a start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken when idle |
| ptr_loc_i | input | 16 | Byte address of the pointer pair |
| cnt_loc_i | input | 16 | Byte address of the count word |
| irq_i | input | 1 | Interrupt request |
| busy_o | output | 1 | Move in progress |
| done_o | output | 1 | One-cycle pulse on normal completion |
| intr_o | output | 1 | One-cycle pulse on interrupted stop |
| mem_addr_o | output | 16 | Memory byte address |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, one cycle after address |

## Verification
Two events can fall on the same transfer boundary: the end of the final transfer and an interrupt request. The bench watches the port for the writeback of the source pointer. It raises `irq_i` right after the k-th such write, for every k from 1 up to the count, with counts from 0 to 6. When k equals the count, the run must end with `done_o`, an unchanged count word and every word copied. For smaller k it must end with `intr_o`, the remaining count stored, exactly k words copied, and a resume that completes the copy.

// File: rtl/wbm_pkg.sv
package wbm_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_RSP, S_RDP, S_RCN, S_CHK, S_RD, S_WR, S_WPS, S_WPD, S_WCN
  } wbm_state_e;
endpackage

// File: rtl/wbm_regs.sv
module wbm_regs #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_src_i,
  input  logic         ld_dst_i,
  input  logic         ld_cnt_i,
  input  logic         step_i,
  input  logic         dec_i,
  input  logic [W-1:0] rdata_i,
  output logic [W-1:0] src_o,
  output logic [W-1:0] dst_o,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] STEP = W'(W / 8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_o <= '0;
      dst_o <= '0;
      cnt_o <= '0;
    end else begin
      if (ld_src_i)    src_o <= rdata_i;
      else if (step_i) src_o <= src_o + STEP;
      if (ld_dst_i)    dst_o <= rdata_i;
      else if (step_i) dst_o <= dst_o + STEP;
      if (ld_cnt_i)    cnt_o <= rdata_i;
      else if (dec_i)  cnt_o <= cnt_o - 1'b1;
    end
  end

  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> (src_o == $past(src_o) + STEP) && (dst_o == $past(dst_o) + STEP)); // R3
  AST_CNT_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |=> cnt_o == $past(cnt_o) - 1'b1); // R4
endmodule

// File: rtl/wbm_port.sv
module wbm_port
  import wbm_pkg::*;
#(
  parameter int W = 16
) (
  input  wbm_state_e   state_i,
  input  logic [W-1:0] ptr_loc_i,
  input  logic [W-1:0] cnt_loc_i,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] dst_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] rdata_i,
  output logic [W-1:0] addr_o,
  output logic         we_o,
  output logic [W-1:0] wdata_o
);
  localparam logic [W-1:0] STEP = W'(W / 8);

  always_comb begin
    addr_o  = '0;
    we_o    = 1'b0;
    wdata_o = '0;
    unique case (state_i)
      S_RSP: addr_o = ptr_loc_i;
      S_RDP: addr_o = ptr_loc_i + STEP;
      S_RCN: addr_o = cnt_loc_i;
      S_RD:  addr_o = src_i;
      S_WR:  begin addr_o = dst_i;            we_o = 1'b1; wdata_o = rdata_i; end
      S_WPS: begin addr_o = ptr_loc_i;        we_o = 1'b1; wdata_o = src_i;   end
      S_WPD: begin addr_o = ptr_loc_i + STEP; we_o = 1'b1; wdata_o = dst_i;   end
      S_WCN: begin addr_o = cnt_loc_i;        we_o = 1'b1; wdata_o = cnt_i;   end
      default: ;
    endcase
  end
endmodule

// File: rtl/wbm_engine.sv
module wbm_engine
  import wbm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] ptr_loc_i,
  input  logic [W-1:0] cnt_loc_i,
  input  logic         irq_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         intr_o,
  output logic [W-1:0] mem_addr_o,
  output logic         mem_we_o,
  output logic [W-1:0] mem_wdata_o,
  input  logic [W-1:0] mem_rdata_i
);
  wbm_state_e   state_q, state_d;
  logic [W-1:0] ptr_loc_q, cnt_loc_q;
  logic [W-1:0] src, dst, cnt;
  logic         last_xfer, zero_cnt;

  assign last_xfer = (cnt == W'(1));
  assign zero_cnt  = (mem_rdata_i == '0);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (start_i) state_d = S_RSP;
      S_RSP:  state_d = S_RDP;
      S_RDP:  state_d = S_RCN;
      S_RCN:  state_d = S_CHK;
      S_CHK:  state_d = zero_cnt ? S_IDLE : S_RD;
      S_RD:   state_d = S_WR;
      S_WR:   state_d = S_WPS;
      S_WPS:  state_d = S_WPD;
      // transfer boundary: the only place irq_i is looked at
      S_WPD:  state_d = last_xfer ? S_IDLE : (irq_i ? S_WCN : S_RD);
      S_WCN:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      ptr_loc_q <= '0;
      cnt_loc_q <= '0;
      done_o    <= 1'b0;
      intr_o    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && start_i) begin
        ptr_loc_q <= ptr_loc_i;
        cnt_loc_q <= cnt_loc_i;
      end
      done_o <= (state_q == S_CHK && zero_cnt) || (state_q == S_WPD && last_xfer);
      intr_o <= (state_q == S_WCN);
    end
  end

  assign busy_o = (state_q != S_IDLE);

  wbm_regs #(.W(W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_src_i(state_q == S_RDP),
    .ld_dst_i(state_q == S_RCN),
    .ld_cnt_i(state_q == S_CHK),
    .step_i  (state_q == S_WR),
    .dec_i   (state_q == S_WPD),
    .rdata_i (mem_rdata_i),
    .src_o   (src),
    .dst_o   (dst),
    .cnt_o   (cnt)
  );

  wbm_port #(.W(W)) u_port (
    .state_i  (state_q),
    .ptr_loc_i(ptr_loc_q),
    .cnt_loc_i(cnt_loc_q),
    .src_i    (src),
    .dst_i    (dst),
    .cnt_i    (cnt),
    .rdata_i  (mem_rdata_i),
    .addr_o   (mem_addr_o),
    .we_o     (mem_we_o),
    .wdata_o  (mem_wdata_o)
  );

  AST_END_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && intr_o)); // R6
  AST_IDLE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_we_o); // R9
  AST_ZERO_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CHK && zero_cnt) |=> done_o && !busy_o); // R5
  AST_CNT_STORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intr_o |-> $past(mem_we_o) && $past(mem_addr_o) == cnt_loc_q); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R4
endmodule

// File: tb/tb_wbm_engine.sv
module tb_wbm_engine;
  localparam logic [15:0] PL = 16'h0040;
  localparam logic [15:0] CL = 16'h0050;
  localparam logic [15:0] SB = 16'h0060;
  localparam logic [15:0] DB = 16'h00A0;

  logic        clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, irq_i = 1'b0;
  logic [15:0] ptr_loc_i = '0, cnt_loc_i = '0;
  logic        busy_o, done_o, intr_o, mem_we_o;
  logic [15:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic [15:0] mem [256];

  int checks = 0, errors = 0, cyc = 0;
  int wr_cnt = 0, wps_n = 0, idle_wr = 0, irq_k = 0;
  logic [15:0] cur_pl = PL;
  bit got_done, got_intr;

  always #2 clk_i = ~clk_i;

  wbm_engine dut (.*);

  function automatic logic [7:0] idx(input logic [15:0] a);
    return a[8:1];
  endfunction

  function automatic logic [15:0] pat(input int n, input int k, input int i);
    return 16'hA500 ^ 16'(n << 12) ^ 16'(k << 8) ^ 16'(i);
  endfunction

  always @(posedge clk_i) begin
    mem_rdata_i <= mem[idx(mem_addr_o)];
    if (mem_we_o) mem[idx(mem_addr_o)] <= mem_wdata_o;
  end

  always @(negedge clk_i) begin
    if (mem_we_o) begin
      wr_cnt++;
      if (!busy_o) idle_wr++;
      if (mem_addr_o == cur_pl) begin
        wps_n++;
        if (irq_k != 0 && wps_n == irq_k) irq_i = 1'b1;
      end
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: act %0d exp <150000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act %h exp %h", req, act, exp);
    end
  endtask

  task automatic setup(input int n, input int k, input logic [15:0] s, input logic [15:0] d);
    for (int i = 0; i < n + 2; i++) begin
      mem[idx(s + 16'(2 * i))] = pat(n, k, i);
      mem[idx(d + 16'(2 * i))] = 16'hDEAD;
    end
    mem[idx(PL)]         = s;
    mem[idx(PL + 16'd2)] = d;
    mem[idx(CL)]         = 16'(n);
  endtask

  // glitch: also pulse start with other locations mid-move
  task automatic go(input int k, input bit glitch);
    int tmo;
    irq_k = k; wr_cnt = 0; wps_n = 0;
    got_done = 0; got_intr = 0;
    @(negedge clk_i);
    start_i = 1'b1; ptr_loc_i = PL; cnt_loc_i = CL;
    @(negedge clk_i);
    start_i = 1'b0; ptr_loc_i = '0; cnt_loc_i = '0;
    chk(busy_o, "R1 busy after start", 32'(busy_o), 1);
    if (glitch) begin
      repeat (6) @(negedge clk_i);
      start_i = 1'b1; ptr_loc_i = 16'h0010; cnt_loc_i = 16'h0012;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    tmo = 0;
    while (!done_o && !intr_o && tmo < 300) begin
      @(negedge clk_i);
      tmo++;
    end
    got_done = done_o; got_intr = intr_o;
    chk(busy_o == 1'b0, "R4 busy low at end", 32'(busy_o), 0);
    @(negedge clk_i);
    irq_i = 1'b0;
    chk(!done_o && !intr_o, "R4 end pulse one cycle", {done_o, intr_o}, 0);
  endtask

  task automatic check_copy(input int n, input int k, input int upto, input string req);
    for (int i = 0; i < n + 1; i++) begin
      logic [15:0] e;
      e = (i < upto) ? pat(n, k, i) : 16'hDEAD;
      chk(mem[idx(DB + 16'(2 * i))] == e, req, mem[idx(DB + 16'(2 * i))], e);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk_i);
    chk({busy_o, done_o, intr_o, mem_we_o} == 0, "R9 reset outputs",
        {busy_o, done_o, intr_o, mem_we_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int n = 0; n <= 6; n++) begin
      for (int k = 0; k <= n; k++) begin
        setup(n, k, SB, DB);
        go(k, 1'b0);
        if (n == 0) begin
          chk(got_done && !got_intr, "R5 zero count done", {got_done, got_intr}, 2);
          chk(wr_cnt == 0, "R5 no writes", wr_cnt, 0);
          chk(mem[idx(PL)] == SB, "R5 src ptr unchanged", mem[idx(PL)], SB);
          chk(mem[idx(PL + 16'd2)] == DB, "R5 dst ptr unchanged", mem[idx(PL + 16'd2)], DB);
        end else if (k == 0 || k == n) begin
          chk(got_done && !got_intr, (k == n) ? "R7 late irq ignored" : "R4 done",
              {got_done, got_intr}, 2);
          check_copy(n, k, n, "R2 copy");
          chk(mem[idx(PL)] == SB + 16'(2 * n), "R3 src writeback", mem[idx(PL)], SB + 16'(2 * n));
          chk(mem[idx(PL + 16'd2)] == DB + 16'(2 * n), "R3 dst writeback",
              mem[idx(PL + 16'd2)], DB + 16'(2 * n));
          chk(mem[idx(CL)] == 16'(n), (k == n) ? "R7 count kept" : "R4 count kept",
              mem[idx(CL)], n);
          chk(wr_cnt == 3 * n, "R4 write count", wr_cnt, 3 * n);
        end else begin
          chk(got_intr && !got_done, "R6 interrupted", {got_done, got_intr}, 1);
          chk(mem[idx(CL)] == 16'(n - k), "R6 remaining count", mem[idx(CL)], n - k);
          check_copy(n, k, k, "R6 stop at boundary");
          chk(mem[idx(PL)] == SB + 16'(2 * k), "R3 src ptr at irq", mem[idx(PL)], SB + 16'(2 * k));
          chk(mem[idx(PL + 16'd2)] == DB + 16'(2 * k), "R3 dst ptr at irq",
              mem[idx(PL + 16'd2)], DB + 16'(2 * k));
          go(0, 1'b0);
          chk(got_done && !got_intr, "R8 resume done", {got_done, got_intr}, 2);
          check_copy(n, k, n, "R8 resume copy");
          chk(mem[idx(PL)] == SB + 16'(2 * n), "R8 src ptr final", mem[idx(PL)], SB + 16'(2 * n));
          chk(mem[idx(CL)] == 16'(n - k), "R8 count kept", mem[idx(CL)], n - k);
        end
      end
    end

    // start while busy must be ignored
    mem[idx(16'h0010)] = 16'h1111;
    mem[idx(16'h0012)] = 16'h0003;
    setup(4, 0, SB, DB);
    go(0, 1'b1);
    chk(got_done, "R9 busy start ignored", 32'(got_done), 1);
    check_copy(4, 0, 4, "R9 copy intact");
    chk(mem[idx(16'h0010)] == 16'h1111, "R9 stray loc untouched", mem[idx(16'h0010)], 16'h1111);

    // pointer wrap FFFE -> 0000
    setup(3, 0, 16'hFFFC, DB);
    go(0, 1'b0);
    chk(got_done, "R3 wrap done", 32'(got_done), 1);
    chk(mem[idx(PL)] == 16'h0002, "R3 src wrap", mem[idx(PL)], 16'h0002);
    chk(mem[idx(DB + 16'd4)] == pat(3, 0, 2), "R3 word after wrap",
        mem[idx(DB + 16'd4)], pat(3, 0, 2));
    chk(mem[idx(PL + 16'd2)] == DB + 16'd6, "R3 dst ptr", mem[idx(PL + 16'd2)], DB + 16'd6);

    chk(idle_wr == 0, "R9 no idle writes", idle_wr, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule